// File: doc/BRIEF.md
# Digital potentiometer wiper control core

This core is the digital half of a 256-position programmable resistor. It holds an 8-bit volatile wiper position and sixteen 8-bit retained setting registers, arranged as four banks of four. It turns the wiper position into a 256-bit switch-enable vector for the tap switches of an external resistor ladder. The serial bus front end and the analog ladder sit outside it. The retained registers are plain flops that keep their contents across the core's reset.

A host issues one command per cycle on a parallel port using a valid/ready handshake. Each command carries a 3-bit opcode, a 4-bit register address and 8-bit write data. Read results come back one cycle after acceptance, qualified by a one-cycle strobe. An active-low protect pin blocks every write into the retained registers. Releasing reset performs a recall: the core copies bank 0, register 0 into the wiper and holds the port off until that copy is done.

Top module: `tapctl_core`

## Requirements
- R1: `tap_en` has exactly one bit set at all times, and that bit is bit k when the wiper position is k.
- R2: Position 0x00 enables `tap_en[0]`, the low-end terminal switch. Position 0xFF enables `tap_en[255]`, the high-end terminal switch.
- R3: The 16 retained registers are addressed by `cmd_addr`, where bits [3:2] select the bank and bits [1:0] select the register in it. Opcode 2 writes `cmd_wdata` to the addressed register. Opcode 3 returns the register's value.
- R4: While reset is asserted, `cmd_ready` is low and the wiper is 0x00. After `rst_n` rises, `cmd_ready` stays low for two clock edges. On the third edge the wiper loads address 0 (bank 0, register 0) and `cmd_ready` goes high. Retained registers keep their contents across reset.
- R5: Opcode 0 writes `cmd_wdata` to the wiper. Opcode 1 returns the wiper. For each read, `rd_valid` is high for exactly the one cycle after acceptance, with the value on `rd_data`, and it is low otherwise.
- R6: Opcode 4 copies the addressed register into the wiper. Opcode 5 copies the wiper into the addressed register.
- R7: Opcode 6 raises the wiper by one and opcode 7 lowers it by one, one step per accepted command.
- R8: Stepping up at 0xFF and stepping down at 0x00 leave the wiper unchanged; it never wraps.
- R9: With `wp_n` low, opcodes 2 and 5 leave the target register unchanged. In the cycle after acceptance, `wr_reject` pulses high for one cycle.
- R10: `wp_n` has no effect on opcodes 0, 4, 6 and 7. These never raise `wr_reject`, and `wr_reject` is high only after a blocked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| wp_n | input | 1 | Active-low protect for retained registers |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Core can accept a command |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | 4 | Register address {bank, index} |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Read data |
| wr_reject | output | 1 | Blocked-write pulse |
| wiper | output | 8 | Current wiper position |
| tap_en | output | 256 | One-hot tap switch enables |

## Verification
The properties assume three things about the host. `cmd_valid` is low while `rst_n` is low. `wp_n` and the command fields stay stable around the sampling edge. The retained registers hold known values before anyone reads them. The stimulus meets these conditions in the following way. It drives all inputs half a cycle away from the edge. It keeps `cmd_valid` low through each reset and its recall window. It writes every register before the first register read or transfer, so the unknown first recall value only reaches the wiper, and a wiper write then overrides it.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;
  typedef enum logic [2:0] {
    OP_WIPER_WR  = 3'd0,
    OP_WIPER_RD  = 3'd1,
    OP_REG_WR    = 3'd2,
    OP_REG_RD    = 3'd3,
    OP_REG2WIPER = 3'd4,
    OP_WIPER2REG = 3'd5,
    OP_STEP_UP   = 3'd6,
    OP_STEP_DN   = 3'd7
  } op_e;
endpackage

// File: rtl/tapctl_rst_sync.sv
module tapctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tapctl_regbank.sv
module tapctl_regbank #(
  parameter int W  = 8,
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  // retained storage: deliberately outside the reset domain
  logic [W-1:0] mem_q [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tapctl_decode.sv
module tapctl_decode #(
  parameter int W = 8
) (
  input  logic [W-1:0]      code,
  output logic [(1<<W)-1:0] onehot
);
  for (genvar i = 0; i < (1 << W); i++) begin : g_tap
    assign onehot[i] = (code == W'(i));
  end
endmodule

// File: rtl/tapctl_core.sv
module tapctl_core #(
  parameter int WIPER_W       = 8,
  parameter int BANKS         = 4,
  parameter int REGS_PER_BANK = 4,
  parameter int ADDR_W        = $clog2(BANKS * REGS_PER_BANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wp_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [2:0]              cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [WIPER_W-1:0]      cmd_wdata,
  output logic                    rd_valid,
  output logic [WIPER_W-1:0]      rd_data,
  output logic                    wr_reject,
  output logic [WIPER_W-1:0]      wiper,
  output logic [(1<<WIPER_W)-1:0] tap_en
);
  import tapctl_pkg::*;

  localparam int NREGS = BANKS * REGS_PER_BANK;
  localparam logic [WIPER_W-1:0] POS_MAX = '1;
  localparam logic [WIPER_W-1:0] POS_MIN = '0;

  logic rst_int_n;
  logic recall_q;
  logic [WIPER_W-1:0] wiper_q, wiper_d;
  logic wiper_en;
  logic rd_valid_q, rd_valid_d;
  logic [WIPER_W-1:0] rd_data_q, rd_data_d;
  logic reject_q, reject_d;
  logic reg_we;
  logic [WIPER_W-1:0] reg_wdata, reg_rdata;
  logic [ADDR_W-1:0] reg_raddr;
  op_e op;

  tapctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  assign reg_raddr = recall_q ? '0 : cmd_addr;

  tapctl_regbank #(.W(WIPER_W), .N(NREGS), .AW(ADDR_W)) u_bank (
    .clk(clk), .wr_en(reg_we), .wr_addr(cmd_addr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata)
  );

  tapctl_decode #(.W(WIPER_W)) u_dec (
    .code(wiper_q), .onehot(tap_en)
  );

  assign op        = op_e'(cmd_op);
  assign cmd_ready = ~recall_q;

  // next-state logic
  always_comb begin
    wiper_d    = wiper_q;
    wiper_en   = 1'b0;
    rd_valid_d = 1'b0;
    rd_data_d  = rd_data_q;
    reject_d   = 1'b0;
    reg_we     = 1'b0;
    reg_wdata  = cmd_wdata;
    if (recall_q) begin
      wiper_d  = reg_rdata;
      wiper_en = 1'b1;
    end else if (cmd_valid) begin
      unique case (op)
        OP_WIPER_WR: begin
          wiper_d  = cmd_wdata;
          wiper_en = 1'b1;
        end
        OP_WIPER_RD: begin
          rd_valid_d = 1'b1;
          rd_data_d  = wiper_q;
        end
        OP_REG_WR: begin
          reg_we   = wp_n;
          reject_d = ~wp_n;
        end
        OP_REG_RD: begin
          rd_valid_d = 1'b1;
          rd_data_d  = reg_rdata;
        end
        OP_REG2WIPER: begin
          wiper_d  = reg_rdata;
          wiper_en = 1'b1;
        end
        OP_WIPER2REG: begin
          reg_wdata = wiper_q;
          reg_we    = wp_n;
          reject_d  = ~wp_n;
        end
        OP_STEP_UP: begin
          wiper_d  = wiper_q + 1'b1;
          wiper_en = (wiper_q != POS_MAX);
        end
        OP_STEP_DN: begin
          wiper_d  = wiper_q - 1'b1;
          wiper_en = (wiper_q != POS_MIN);
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      recall_q   <= 1'b1;
      wiper_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      reject_q   <= 1'b0;
    end else begin
      recall_q   <= 1'b0;
      if (wiper_en)   wiper_q   <= wiper_d;
      rd_valid_q <= rd_valid_d;
      if (rd_valid_d) rd_data_q <= rd_data_d;
      reject_q   <= reject_d;
    end
  end

  assign wiper     = wiper_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign wr_reject = reject_q;
endmodule

// File: rtl/tapctl_chk.sv
module tapctl_chk #(
  parameter int WIPER_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wp_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [2:0]              cmd_op,
  input logic                    rd_valid,
  input logic                    wr_reject,
  input logic [WIPER_W-1:0]      wiper,
  input logic [(1<<WIPER_W)-1:0] tap_en
);
  import tapctl_pkg::*;

  logic acc;
  logic is_prot;
  assign acc     = cmd_valid && cmd_ready;
  assign is_prot = (cmd_op == OP_REG_WR) || (cmd_op == OP_WIPER2REG);

  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) == 1);

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_STEP_UP && wiper != '1) |=> wiper == WIPER_W'($past(wiper) + 1'b1));

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_STEP_UP && wiper == '1) |=> wiper == '1);

  // R8
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_STEP_DN && wiper == '0) |=> wiper == '0);

  // R9
  prot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wp_n && is_prot) |=> wr_reject);

  // R10
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(acc && !wp_n && is_prot));

  // R5
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc && (cmd_op == OP_WIPER_RD || cmd_op == OP_REG_RD)));
endmodule

bind tapctl_core tapctl_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .rd_valid(rd_valid),
  .wr_reject(wr_reject), .wiper(wiper), .tap_en(tap_en)
);

// File: tb/sim_tapctl_core.sv
`timescale 1ns/1ps
module sim_tapctl_core;
  logic clk = 1'b0;
  logic rst_n, wp_n, cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_wdata, rd_data, wiper;
  logic rd_valid, wr_reject;
  logic [255:0] tap_en;

  always #2 clk = ~clk;

  tapctl_core u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_reject(wr_reject), .wiper(wiper), .tap_en(tap_en)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mdl_upd = 0, mdl_cmp = 0;
  logic [7:0] exp_wiper = 8'h00, exp_rd = 8'h00;
  logic exp_rdv = 1'b0, exp_rej = 1'b0;
  logic [7:0] exp_regs [16];

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model: behavioural update on each accepted command
  always @(posedge clk) begin
    if (mdl_upd) begin
      exp_rdv = 1'b0;
      exp_rej = 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          3'd0: exp_wiper = cmd_wdata;
          3'd1: begin exp_rdv = 1'b1; exp_rd = exp_wiper; end
          3'd2: if (wp_n) exp_regs[cmd_addr] = cmd_wdata; else exp_rej = 1'b1;
          3'd3: begin exp_rdv = 1'b1; exp_rd = exp_regs[cmd_addr]; end
          3'd4: exp_wiper = exp_regs[cmd_addr];
          3'd5: if (wp_n) exp_regs[cmd_addr] = exp_wiper; else exp_rej = 1'b1;
          3'd6: if (exp_wiper < 8'hFF) exp_wiper = exp_wiper + 8'd1;
          default: if (exp_wiper > 8'h00) exp_wiper = exp_wiper - 8'd1;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_cmp) begin
      chk("R4 ready", 256'(cmd_ready), 256'(1'b1));
      chk("R5/R6/R7/R8 wiper", 256'(wiper), 256'(exp_wiper));
      chk("R1 tap_en", tap_en, 256'(1) << exp_wiper);
      chk("R5 rd_valid", 256'(rd_valid), 256'(exp_rdv));
      if (exp_rdv) chk("R3/R5 rd_data", 256'(rd_data), 256'(exp_rd));
      chk("R9/R10 wr_reject", 256'(wr_reject), 256'(exp_rej));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<60000", cyc);
      finish_run();
    end
  end

  task automatic send(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(input bit check_recall);
    mdl_upd = 0; mdl_cmp = 0;
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R4 reset state
    chk("R4 reset ready", 256'(cmd_ready), 256'(1'b0));
    chk("R4 reset wiper", 256'(wiper), 256'(8'h00));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 ready low 1", 256'(cmd_ready), 256'(1'b0));
    @(negedge clk);
    chk("R4 ready low 2", 256'(cmd_ready), 256'(1'b0));
    @(negedge clk);
    chk("R4 ready high", 256'(cmd_ready), 256'(1'b1));
    if (check_recall) begin
      chk("R4 recall", 256'(wiper), 256'(exp_regs[0]));
      exp_wiper = exp_regs[0];
      mdl_cmp = 1;
    end
    exp_rdv = 1'b0; exp_rej = 1'b0;
    mdl_upd = 1;
  endtask

  initial begin
    wp_n = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
    do_reset(1'b0);
    send(3'd0, 4'd0, 8'h5A);
    mdl_cmp = 1;
    for (int i = 0; i < 16; i++) send(3'd2, 4'(i), 8'(i * 17 + 3));
    for (int i = 15; i >= 0; i--) send(3'd3, 4'(i), 8'h00);   // R3
    send(3'd1, 4'd0, 8'h00);                                  // R5
    @(negedge clk);
    send(3'd4, 4'd5, 8'h00);                                  // R6
    send(3'd5, 4'd9, 8'h00);
    send(3'd3, 4'd9, 8'h00);
    repeat (3) send(3'd6, 4'd0, 8'h00);                       // R7
    repeat (2) send(3'd7, 4'd0, 8'h00);
    send(3'd0, 4'd0, 8'hFE);
    repeat (2) send(3'd6, 4'd0, 8'h00);                       // R8
    chk("R2 high end", 256'(tap_en[255]), 256'(1'b1));
    send(3'd0, 4'd0, 8'h01);
    repeat (2) send(3'd7, 4'd0, 8'h00);                       // R8
    chk("R2 low end", 256'(tap_en[0]), 256'(1'b1));
    wp_n = 1'b0;
    send(3'd2, 4'd3, 8'hEE);                                  // R9
    @(negedge clk);
    send(3'd3, 4'd3, 8'h00);
    send(3'd5, 4'd0, 8'h00);                                  // R9
    send(3'd3, 4'd0, 8'h00);
    send(3'd0, 4'd0, 8'h33);                                  // R10
    send(3'd4, 4'd7, 8'h00);
    send(3'd6, 4'd0, 8'h00);
    send(3'd7, 4'd0, 8'h00);
    @(negedge clk);
    wp_n = 1'b1;
    send(3'd2, 4'd0, 8'hC4);
    send(3'd3, 4'd0, 8'h00);
    @(negedge clk);
    do_reset(1'b1);                                           // R4 recall of 0xC4
    send(3'd3, 4'd9, 8'h00);                                  // R4 retention
    send(3'd3, 4'd3, 8'h00);
    for (int k = 0; k < 256; k++) send(3'd0, 4'd0, 8'(k));    // R1 sweep
    @(negedge clk);
    finish_run();
  end
endmodule